// File: doc/BRIEF.md
# Raster Frame and Pixel Counter

This block tracks scan-out progress for one display pipe. A pixel counter runs on every enabled pixel clock and returns to zero when the horizontal-active strobe and the first-active-line strobe arrive together. At that same point a frame counter, `FRAME_W` bits wide, advances by one. Both counters therefore mark frame boundaries at the start of active video.

Software usually wants a count that advances at the start of vertical blanking. The block derives that count by comparing the pixel counter with a threshold. The threshold is `vblank_start*htotal - (htotal - hsync_start)`. It is taken once per frame into a register, at the frame boundary.

A snapshot strobe copies the frame and pixel counters on the same edge. This gives a 32-bit readback word (pixel count in the low field, low frame bits above it) and a separate upper-frame field. The two parts are always mutually consistent. A disable input forces the derived count to zero when the counter is declared non-functional.

Top module: `raster_frame_counter`

## Requirements
- R1: During and after reset, before any enabled clock, the pixel count, frame count, vblank count, readback word and upper-frame field are all zero.
- R2: On an enabled clock with no frame boundary, the pixel count increases by one, modulo 2^PIX_W.
- R3: On an enabled clock where `hact_start` and `first_line` are both 1, the pixel count becomes 0 and the frame count increases by one on the next cycle.
- R4: While `en` is 0, the pixel and frame counts hold their values.
- R5: The frame count and the vblank count wrap modulo 2^FRAME_W. When the frame count is all ones and the pixel count has reached the threshold, the vblank count reads 0.
- R6: When `count_off` is 0, the vblank count equals (frame + (pixel >= threshold)) mod 2^FRAME_W, with threshold = vblank_start*htotal - htotal + hsync_start.
- R7: The threshold is loaded only on an enabled frame boundary, from the timing inputs present on that cycle. Timing changes in the middle of a frame take effect at the next boundary. Before the first boundary after reset, the comparison is false.
- R8: While `count_off` is 1, the vblank count is 0.
- R9: On a cycle with `snap` at 1, the readback word becomes {frame[LO_W-1:0], pixel}, with the pixel in bits PIX_W-1:0 and LO_W = 32 - PIX_W. The upper-frame output becomes frame[FRAME_W-1:LO_W]. Both are taken from the counter values before that edge, and both hold until the next snap.
- R10: `hact_start` without `first_line`, or `first_line` without `hact_start`, is not a frame boundary: the pixel count keeps counting and the frame count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Counting enable |
| htotal | input | H_W | Pixels per line |
| hsync_start | input | H_W | Pixel position of hsync start within a line |
| vblank_start | input | V_W | Line number where vertical blanking starts (at least 1) |
| hact_start | input | 1 | Strobe: start of horizontal active |
| first_line | input | 1 | Level: current line is the first active line |
| count_off | input | 1 | Counter declared non-functional; vblank count forced to 0 |
| snap | input | 1 | Capture strobe for the readback outputs |
| pix_count | output | PIX_W | Live pixel count since frame start |
| frame_count | output | FRAME_W | Live frame count |
| rdback_word | output | 32 | Captured {frame low bits, pixel count} |
| rdback_frame_hi | output | FRAME_W-LO_W | Captured upper frame bits |
| vblank_count | output | FRAME_W | Vblank-aligned frame count |

## Verification
The hardest situation to reach is the wrap of the vblank count. It needs the frame counter at all ones while the pixel counter is past the threshold, and at full width that takes an enormous number of frames. The bench therefore builds the block with a narrow frame counter and holds both frame-boundary strobes high on every cycle until the counter reaches all ones. It then releases the strobes and lets the pixel count climb past the threshold. A second awkward case is a change of timing in the middle of a frame. The stimulus switches geometry partway through a frame and checks that the old threshold stays in force until the next boundary.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int unsigned WORD_W = 32;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rfc_rst_sync.sv
module rfc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/rfc_raster_cnt.sv
module rfc_raster_cnt #(
  parameter int unsigned PIX_W   = 24,
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               frame_evt,
  output logic [PIX_W-1:0]   pix_q,
  output logic [FRAME_W-1:0] frame_q
);
  logic [PIX_W-1:0]   pix_d;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    pix_d   = pix_q;
    frame_d = frame_q;
    if (en) begin
      if (frame_evt) begin
        pix_d   = '0;
        frame_d = frame_q + FRAME_W'(1);
      end else begin
        pix_d   = pix_q + PIX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q   <= '0;
      frame_q <= '0;
    end else begin
      pix_q   <= pix_d;
      frame_q <= frame_d;
    end
  end
endmodule

// File: rtl/rfc_vbl_thresh.sv
module rfc_vbl_thresh #(
  parameter int unsigned H_W   = 13,
  parameter int unsigned V_W   = 13,
  localparam int unsigned THR_W = H_W + V_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [H_W-1:0]   htotal,
  input  logic [H_W-1:0]   hsync_start,
  input  logic [V_W-1:0]   vblank_start,
  output logic [THR_W-1:0] thr_q
);
  logic [THR_W-1:0] prod_w;
  logic [THR_W-1:0] thr_d;

  // Product of line count and line length, then pulled back to the hsync edge.
  assign prod_w = THR_W'(vblank_start) * THR_W'(htotal);

  always_comb begin
    thr_d = thr_q;
    if (load) begin
      thr_d = prod_w - THR_W'(htotal) + THR_W'(hsync_start);
    end
  end

  // All ones at reset keeps the compare false until the first frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '1;
    end else begin
      thr_q <= thr_d;
    end
  end
endmodule

// File: rtl/rfc_snapshot.sv
module rfc_snapshot #(
  parameter int unsigned PIX_W   = 24,
  parameter int unsigned FRAME_W = 24,
  localparam int unsigned LO_W   = rfc_pkg::WORD_W - PIX_W,
  localparam int unsigned HI_W   = FRAME_W - LO_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      snap,
  input  logic [PIX_W-1:0]          pix,
  input  logic [FRAME_W-1:0]        frame,
  output logic [rfc_pkg::WORD_W-1:0] word,
  output logic [HI_W-1:0]           frame_hi
);
  logic [PIX_W-1:0]   pix_s_q,   pix_s_d;
  logic [FRAME_W-1:0] frame_s_q, frame_s_d;

  always_comb begin
    pix_s_d   = pix_s_q;
    frame_s_d = frame_s_q;
    if (snap) begin
      pix_s_d   = pix;
      frame_s_d = frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_s_q   <= '0;
      frame_s_q <= '0;
    end else begin
      pix_s_q   <= pix_s_d;
      frame_s_q <= frame_s_d;
    end
  end

  assign word     = {frame_s_q[LO_W-1:0], pix_s_q};
  assign frame_hi = frame_s_q[FRAME_W-1:LO_W];
endmodule

// File: rtl/raster_frame_counter.sv
module raster_frame_counter #(
  parameter int unsigned PIX_W   = 24,
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned H_W     = 13,
  parameter int unsigned V_W     = 13,
  localparam int unsigned LO_W   = rfc_pkg::WORD_W - PIX_W,
  localparam int unsigned HI_W   = FRAME_W - LO_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [H_W-1:0]             htotal,
  input  logic [H_W-1:0]             hsync_start,
  input  logic [V_W-1:0]             vblank_start,
  input  logic                       hact_start,
  input  logic                       first_line,
  input  logic                       count_off,
  input  logic                       snap,
  output logic [PIX_W-1:0]           pix_count,
  output logic [FRAME_W-1:0]         frame_count,
  output logic [rfc_pkg::WORD_W-1:0] rdback_word,
  output logic [HI_W-1:0]            rdback_frame_hi,
  output logic [FRAME_W-1:0]         vblank_count
);
  localparam int unsigned THR_W = H_W + V_W;
  localparam int unsigned CMP_W = rfc_pkg::max_w(PIX_W, THR_W);

  logic             rst_sync_n;
  logic             frame_evt;
  logic [THR_W-1:0] thr_q;
  logic             past_thr;

  assign frame_evt = hact_start & first_line;

  rfc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rfc_raster_cnt #(.PIX_W(PIX_W), .FRAME_W(FRAME_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (en),
    .frame_evt (frame_evt),
    .pix_q     (pix_count),
    .frame_q   (frame_count)
  );

  rfc_vbl_thresh #(.H_W(H_W), .V_W(V_W)) u_thr (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .load         (en & frame_evt),
    .htotal       (htotal),
    .hsync_start  (hsync_start),
    .vblank_start (vblank_start),
    .thr_q        (thr_q)
  );

  rfc_snapshot #(.PIX_W(PIX_W), .FRAME_W(FRAME_W)) u_snap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .snap     (snap),
    .pix      (pix_count),
    .frame    (frame_count),
    .word     (rdback_word),
    .frame_hi (rdback_frame_hi)
  );

  assign past_thr     = CMP_W'(pix_count) >= CMP_W'(thr_q);
  assign vblank_count = count_off ? '0 : (frame_count + FRAME_W'(past_thr));
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int unsigned PIX_W   = 24,
  parameter int unsigned FRAME_W = 24,
  parameter int unsigned HI_W    = 16
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic                       en,
  input logic                       hact_start,
  input logic                       first_line,
  input logic                       count_off,
  input logic                       snap,
  input logic [PIX_W-1:0]           pix_count,
  input logic [FRAME_W-1:0]         frame_count,
  input logic [rfc_pkg::WORD_W-1:0] rdback_word,
  input logic [HI_W-1:0]            rdback_frame_hi,
  input logic [FRAME_W-1:0]         vblank_count
);
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en && !(hact_start && first_line) |=> pix_count == $past(pix_count) + PIX_W'(1)); // R2

  AST_FRAME_EVT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en && hact_start && first_line |=> pix_count == '0 && frame_count == $past(frame_count) + FRAME_W'(1)); // R3

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> $stable(pix_count) && $stable(frame_count)); // R4

  AST_VBL_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    count_off |-> vblank_count == '0); // R8

  AST_VBL_NEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !count_off |-> (vblank_count == frame_count) || (vblank_count == frame_count + FRAME_W'(1))); // R6

  AST_SNAP_PIX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    snap |=> rdback_word[PIX_W-1:0] == $past(pix_count)); // R9

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !snap |=> $stable(rdback_word) && $stable(rdback_frame_hi)); // R9
endmodule

bind raster_frame_counter rfc_checker #(
  .PIX_W(PIX_W), .FRAME_W(FRAME_W), .HI_W(HI_W)
) u_chk (
  .clk             (clk),
  .rst_sync_n      (rst_sync_n),
  .en              (en),
  .hact_start      (hact_start),
  .first_line      (first_line),
  .count_off       (count_off),
  .snap            (snap),
  .pix_count       (pix_count),
  .frame_count     (frame_count),
  .rdback_word     (rdback_word),
  .rdback_frame_hi (rdback_frame_hi),
  .vblank_count    (vblank_count)
);

// File: tb/raster_frame_counter_tb.sv
module raster_frame_counter_tb;
  localparam int unsigned PW = 22;
  localparam int unsigned FW = 12;
  localparam int unsigned HW = 13;
  localparam int unsigned VW = 13;
  localparam int unsigned LO = 32 - PW;
  localparam int unsigned HI = FW - LO;
  localparam longint PM = (64'd1 << PW) - 1;
  localparam longint FM = (64'd1 << FW) - 1;
  localparam longint LM = (64'd1 << LO) - 1;

  logic clk = 1'b0;
  logic rst_n, en, hact, fl, off, snap;
  logic [HW-1:0] ht, hss;
  logic [VW-1:0] vbs;
  logic [PW-1:0] pix;
  logic [FW-1:0] frm, vbl;
  logic [31:0]   word;
  logic [HI-1:0] fhi;

  always #2 clk = ~clk;

  raster_frame_counter #(.PIX_W(PW), .FRAME_W(FW), .H_W(HW), .V_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .htotal(ht), .hsync_start(hss),
    .vblank_start(vbs), .hact_start(hact), .first_line(fl), .count_off(off),
    .snap(snap), .pix_count(pix), .frame_count(frm), .rdback_word(word),
    .rdback_frame_hi(fhi), .vblank_count(vbl)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  longint mpix = 0, mfrm = 0, mthr = 64'd1 << 40, spix = 0, sfrm = 0;
  int col = 0, line = 2, cur_ht = 10, cur_hss = 7, cur_vbs = 4, cur_vt = 6;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    longint ev;
    ev = off ? 0 : ((mfrm + ((mpix >= mthr) ? 1 : 0)) & FM);
    chk("R2", "pix_count", longint'(pix), mpix);
    chk("R3", "frame_count", longint'(frm), mfrm);
    chk(off ? "R8" : tag, "vblank_count", longint'(vbl), ev);
    chk("R9", "rdback_word", longint'(word), ((sfrm & LM) << PW) | spix);
    chk("R9", "rdback_frame_hi", longint'(fhi), sfrm >> LO);
  endtask

  // Inputs are already driven; one clock with model update, compare at negedge.
  task automatic step(input string tag);
    @(posedge clk);
    if (snap) begin spix = mpix; sfrm = mfrm; end
    if (en) begin
      if (hact && fl) begin
        mpix = 0; mfrm = (mfrm + 1) & FM;
        mthr = longint'(vbs) * longint'(ht) - longint'(ht) + longint'(hss);
      end else begin
        mpix = (mpix + 1) & PM;
      end
    end
    @(negedge clk);
    cyc++;
    check_all(tag);
  endtask

  // Drive raster strobes from the bench geometry and advance it on enabled clocks.
  task automatic raster(input int n, input int en_gap, input string tag);
    for (int i = 0; i < n; i++) begin
      en   = (en_gap == 0) ? 1'b1 : (($urandom % en_gap) != 0);
      ht   = HW'(cur_ht); hss = HW'(cur_hss); vbs = VW'(cur_vbs);
      hact = (col == 0); fl = (line == 0);
      snap = ((cyc % 17) == 5);
      step(tag);
      if (en) begin
        col++;
        if (col >= cur_ht) begin col = 0; line = (line + 1) % cur_vt; end
      end
    end
  endtask

  initial begin
    #(4ns * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 0; hact = 0; fl = 0; off = 0; snap = 0;
    ht = 10; hss = 7; vbs = 4;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step("R1");
    // R1: everything still zero with enable low across reset release
    chk("R1", "pix after reset", longint'(pix), 0);
    chk("R1", "word after reset", longint'(word), 0);

    // R7: compare false before first boundary; then several frames (R2 R3 R6 R10)
    raster(40, 0, "R7");
    raster(200, 0, "R6");
    // R10: lines other than the first carry hact without first_line, and vice versa
    chk("R10", "frames after run", longint'(frm), mfrm);

    // R4: enable gaps
    raster(150, 3, "R4");

    // R7: change geometry partway through a frame
    while (!(line == 3 && col == 0)) raster(1, 0, "R7");
    cur_ht = 8; cur_hss = 5; cur_vbs = 3; cur_vt = 5;
    raster(160, 0, "R7");

    // R8: forced off
    off = 1'b1;
    raster(60, 0, "R8");
    off = 1'b0;

    // R5: drive back-to-back boundaries until the frame count is all ones
    en = 1; hact = 1; fl = 1; snap = 0;
    while (mfrm != FM) step("R5");
    hact = 0; fl = 0;
    for (int i = 0; i < 30; i++) step("R5");
    chk("R5", "vblank wrapped", longint'(vbl), 0);
    snap = 1; step("R9"); snap = 0; step("R9");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule